// File: doc/BRIEF.md
# Jump-Buffered Program Sequencer

This block sequences instruction fetch for a small bit-serial controller. It keeps a program counter that is driven straight out as the instruction ROM address. Once per completed instruction it either moves the counter to the next location or, on a jump, loads it from a branch target buffer.

The branch target buffer is written one bit per instruction, most-significant bit first. Every write shifts the buffer left by one and places the new bit at the least-significant end, so after as many writes as the counter has bits the buffer holds the full target. A jump is always unconditional. To branch on a condition, the decoder places a skip request in the instruction just before the jump. The skip request raises a flag, and while that flag is high the next completed instruction has no effect except that the counter still steps by one.

Instruction decode and ROM contents sit outside this block. The decoder presents a completion strobe with the jump, skip and buffer-write qualifiers for that instruction. It reads the skip flag, which marks the instruction now being fetched as one that will be dropped.

Top module: `prog_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter, the branch target buffer and the skip flag all become 0. A jump taken as the first instruction after reset therefore goes to address 0.
- R2: When an instruction completes (`step_i` high), the skip flag is low and `jump_i` is low, `pc_o` equals the previous value plus one from the next cycle on.
- R3: Incrementing from the all-ones address (0x1FFFF at the default width) gives 0.
- R4: When an instruction completes with the skip flag low and `dst_wr_i` high, the buffer shifts left by one and `dst_bit_i` enters bit 0. After 17 such writes, a jump lands on the value whose bits were written most-significant first.
- R5: When an instruction completes with the skip flag low and `jump_i` high, `pc_o` takes the buffer contents as they stood before any write in that same cycle.
- R6: When an instruction completes with the skip flag low, `skip_o` takes the value of `skip_req_i` from the next cycle on.
- R7: When an instruction completes with `skip_o` high, the counter steps by one, `skip_o` clears, and `jump_i`, `skip_req_i` and `dst_wr_i` are ignored. The buffer is left unchanged.
- R8: Without `step_i`, `pc_o`, `skip_o` and the buffer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Current instruction completes this cycle |
| jump_i | input | 1 | Completing instruction is a jump |
| skip_req_i | input | 1 | Completing instruction requests a skip of the next one |
| dst_wr_i | input | 1 | Completing instruction writes one bit to the branch target buffer |
| dst_bit_i | input | 1 | Bit written to the branch target buffer |
| pc_o | output | PC_W (17) | Program counter, instruction ROM address |
| skip_o | output | 1 | Instruction being fetched will be skipped |

## Verification
The bench builds the block at the default width of 17 bits. With that width, filling the buffer with ones and jumping reaches the top address in a few dozen cycles, so the wrap to zero is checked directly. Targets written across the full width show that the most-significant-first ordering spans every bit. Random instruction mixes, with frequent skips ahead of jumps and writes, exercise the skipped-instruction path against a bench model.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DEF_PC_W = 17;

  // qualified per-instruction actions after skip gating
  typedef struct packed {
    logic adv;    // counter moves this cycle
    logic jump;   // counter loads target
    logic shift;  // target buffer takes a bit
    logic skset;  // next skip flag value when adv
  } seq_cmd_t;
endpackage

// File: rtl/seq_skip_ctl.sv
module seq_skip_ctl
  import seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step_i,
  input  logic     jump_i,
  input  logic     skip_req_i,
  input  logic     dst_wr_i,
  output seq_cmd_t cmd_o,
  output logic     skip_o
);
  logic skip_q;
  logic live;

  assign live = step_i & ~skip_q;

  always_comb begin
    cmd_o.adv   = step_i;
    cmd_o.jump  = live & jump_i;
    cmd_o.shift = live & dst_wr_i;
    cmd_o.skset = live & skip_req_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      skip_q <= 1'b0;
    else if (step_i) skip_q <= cmd_o.skset;
  end

  assign skip_o = skip_q;

  // a skipped instruction always clears the flag
  p_skip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && skip_q) |=> !skip_q);
  // a live skip request raises the flag
  p_skip_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !skip_q && skip_req_i) |=> skip_q);
  // no completion, no change
  p_skip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(skip_q));
endmodule

// File: rtl/seq_dst_buf.sv
module seq_dst_buf #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] dst_o
);
  logic [W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       dst_q <= '0;
    else if (shift_i) dst_q <= {dst_q[W-2:0], bit_i};
  end

  assign dst_o = dst_q;

  p_dst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(dst_q));
  p_dst_newbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> dst_q[0] == $past(bit_i));
endmodule

// File: rtl/seq_pc_reg.sv
module seq_pc_reg #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         jump_i,
  input  logic [W-1:0] target_i,
  output logic [W-1:0] pc_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] TOPA = '1;

  logic [W-1:0] pc_q;
  logic [W-1:0] pc_nx;

  always_comb begin
    if (jump_i) pc_nx = target_i;
    else        pc_nx = pc_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pc_q <= '0;
    else if (adv_i) pc_q <= pc_nx;
  end

  assign pc_o = pc_q;

  p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(pc_q));
  p_pc_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && jump_i) |=> pc_q == $past(target_i));
  p_pc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !jump_i && pc_q == TOPA) |=> pc_q == '0);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !jump_i && pc_q != TOPA) |=> pc_q > $past(pc_q));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import seq_pkg::*;
#(
  parameter int PC_W = DEF_PC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic            jump_i,
  input  logic            skip_req_i,
  input  logic            dst_wr_i,
  input  logic            dst_bit_i,
  output logic [PC_W-1:0] pc_o,
  output logic            skip_o
);
  seq_cmd_t        cmd;
  logic [PC_W-1:0] target;

  seq_skip_ctl u_skip (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .jump_i     (jump_i),
    .skip_req_i (skip_req_i),
    .dst_wr_i   (dst_wr_i),
    .cmd_o      (cmd),
    .skip_o     (skip_o)
  );

  seq_dst_buf #(.W(PC_W)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (cmd.shift),
    .bit_i   (dst_bit_i),
    .dst_o   (target)
  );

  seq_pc_reg #(.W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (cmd.adv),
    .jump_i   (cmd.jump),
    .target_i (target),
    .pc_o     (pc_o)
  );

  // reset leaves the sequencer at address 0 with no skip pending
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && !skip_o));
endmodule

// File: tb/sim_prog_seq.sv
module sim_prog_seq;
  localparam int W = 17;
  localparam time TCK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, jump_i = 1'b0, skip_req_i = 1'b0;
  logic dst_wr_i = 1'b0, dst_bit_i = 1'b0;
  logic [W-1:0] pc_o;
  logic skip_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  logic [W-1:0] m_pc, m_dst;
  logic m_skip;

  always #(TCK/2) clk = ~clk;

  prog_seq #(.PC_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
    .skip_req_i(skip_req_i), .dst_wr_i(dst_wr_i), .dst_bit_i(dst_bit_i),
    .pc_o(pc_o), .skip_o(skip_o)
  );

  function automatic logic [W-1:0] shl(input logic [W-1:0] d, input logic b);
    return {d[W-2:0], b};
  endfunction

  task automatic chk_pc(input string tag, input logic [W-1:0] exp);
    checks++;
    if (pc_o !== exp) begin
      bad++;
      $display("FAIL %s pc actual=%h expected=%h", tag, pc_o, exp);
    end
  endtask

  task automatic chk_sk(input string tag, input logic exp);
    checks++;
    if (skip_o !== exp) begin
      bad++;
      $display("FAIL %s skip actual=%b expected=%b", tag, skip_o, exp);
    end
  endtask

  // drive one cycle at negedge, update model, check at the next negedge
  task automatic op(input logic s, input logic j, input logic k,
                    input logic w, input logic b, input string tag);
    logic [W-1:0] nd;
    step_i = s; jump_i = j; skip_req_i = k; dst_wr_i = w; dst_bit_i = b;
    if (s) begin
      if (m_skip) begin
        m_pc = m_pc + W'(1);       // R7
        m_skip = 1'b0;
      end else begin
        nd = w ? shl(m_dst, b) : m_dst;
        m_pc = j ? m_dst : m_pc + W'(1);
        m_skip = k;
        m_dst = nd;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk_pc(tag, m_pc);
    chk_sk(tag, m_skip);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step_i = 1'b1; jump_i = 1'b0; skip_req_i = 1'b1; dst_wr_i = 1'b1; dst_bit_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_dst = '0; m_skip = 1'b0;
    chk_pc("R1", '0);
    chk_sk("R1", 1'b0);
  endtask

  task automatic load_target(input logic [W-1:0] v, input string tag);
    for (int i = W-1; i >= 0; i--) op(1'b1, 1'b0, 1'b0, 1'b1, v[i], tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [W-1:0] pat;
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R1: buffer cleared, jump goes to 0
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    // R8: idle cycles hold
    op(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    // R4: MSB-first target
    pat = 17'h1A5C3;
    load_target(pat, "R4");
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    chk_pc("R4", pat);
    // R5: jump with write in the same cycle uses old buffer
    op(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    chk_pc("R5", pat);
    // R3: wrap from all ones
    load_target('1, "R3");
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    chk_pc("R3", '0);
    // R6/R7: skip then jump is dropped, write ignored
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    chk_sk("R6", 1'b1);
    op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    op(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    chk_pc("R7", 17'h00002);
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");  // buffer untouched by skipped write
    // R6: no skip request clears flag path
    op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic s, j, k, w, b;
      s = ($urandom % 4) != 0;
      j = ($urandom % 6) == 0;
      k = ($urandom % 4) == 0;
      w = ($urandom % 2) == 0;
      b = $urandom % 2;
      op(s, j, k, w, b, s ? (j ? "R5" : "R2") : "R8");
    end
    // R1: reset mid-run
    do_reset();
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule